// File: doc/BRIEF.md
# Loop Time-Constant Step Scheduler

This block chooses the loop time constants used by the two phase-locked loops of a broadcast data demodulator. One is the carrier-recovery loop, with a 1-bit constant. The other is the data bit-clock loop, with a 2-bit constant. Fast constants give quick acquisition after a retune. Slow constants give the best noise immunity once the loops are locked.

In hardware mode, a resynchronization pulse sends both loops back to their fastest constants. The block then counts data bit-clock strobes and relaxes the constants in fixed steps of 64 strobes until the slowest setting is reached. The slowest setting is held until the next resynchronization.

In software mode, two register fields drive the constants directly, and each loop is set independently of the other. The step schedule keeps running in the background in software mode, so a return to hardware mode shows the current position in the schedule.

Top module: `pll_tc_sched`

## Requirements
- R1: After a synchronous reset (rst high at a rising edge), carrier_sel is 0 and bit_sel is 00.
- R2: The encodings are as follows. carrier_sel 0 is the fast carrier constant and 1 is the slow one. bit_sel 00 is the fastest bit-loop constant, followed by 01 and 10, with 11 the slowest.
- R3: src_sw = 0 selects the hardware schedule. src_sw = 1 selects the software fields. The outputs are registered and reflect the selected source one clock after it is sampled.
- R4: In hardware mode, a resync pulse makes the outputs show carrier_sel 0 and bit_sel 00 from the clock after the pulse is sampled.
- R5: Counted from the last resync or reset, the 64th bit strobe gives carrier_sel 1 and bit_sel 01. The 128th strobe gives bit_sel 10, and the 192nd gives bit_sel 11. Each change appears one clock after the edge that samples that strobe.
- R6: Once bit_sel reaches 11 with carrier_sel 1, further strobes change nothing until the next resync or reset.
- R7: A resync that arrives part-way through a step restarts the count from zero, so the next step occurs only after 64 further strobes.
- R8: When resync and bit_stb are high in the same cycle, the resync takes effect and that strobe is not counted.
- R9: Cycles in which bit_stb is low do not advance the schedule.
- R10: In software mode, carrier_sel follows sw_carrier and bit_sel follows sw_bit. Each output follows its own field independently of the other, and a resync does not change the outputs.
- R11: The schedule keeps counting and honours resync while software mode is selected. On a return to hardware mode, the outputs show the schedule's current step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_stb | input | 1 | One-cycle strobe per recovered data bit |
| resync | input | 1 | One-cycle resynchronization request |
| src_sw | input | 1 | Source select: 0 = hardware schedule, 1 = software fields |
| sw_carrier | input | 1 | Software carrier-loop constant |
| sw_bit | input | 2 | Software bit-loop constant |
| carrier_sel | output | 1 | Carrier-loop time-constant select |
| bit_sel | output | 2 | Bit-loop time-constant select |

## Verification
A wrong step-counter state in hardware mode shows up as a select change at the wrong strobe count. Examples are a step arriving after 63 or 65 strobes, a step that a resync failed to cancel, or a move away from the slowest setting. Each such error shows on bit_sel, and on carrier_sel at the first boundary, one clock after the offending strobe. The bench therefore checks the outputs on both sides of every boundary. A fault in the source mux shows up within one clock of a change to src_sw or to the software fields.

// File: rtl/pllsched_pkg.sv
package pllsched_pkg;
  typedef enum logic {
    TC_SRC_HW = 1'b0,
    TC_SRC_SW = 1'b1
  } tc_src_e;

  localparam int unsigned DEF_STEP_LEN = 64;
  localparam int unsigned DEF_BL_W     = 2;
endpackage

// File: rtl/pllsched_step_ctr.sv
module pllsched_step_ctr #(
  parameter int unsigned STEP_LEN = pllsched_pkg::DEF_STEP_LEN,
  parameter int unsigned STEP_W   = pllsched_pkg::DEF_BL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_stb,
  input  logic              resync,
  output logic [STEP_W-1:0] step
);
  localparam int unsigned SUB_W     = (STEP_LEN > 1) ? $clog2(STEP_LEN) : 1;
  localparam int unsigned NUM_STEPS = 1 << STEP_W;
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(NUM_STEPS - 1);
  localparam logic [SUB_W-1:0]  SUB_END   = SUB_W'(STEP_LEN - 1);

  logic [SUB_W-1:0] sub_q;
  logic [STEP_W-1:0] step_q;

  always_ff @(posedge clk) begin
    if (rst || resync) begin
      sub_q  <= '0;
      step_q <= '0;
    end else if (bit_stb && step_q != LAST_STEP) begin
      if (sub_q == SUB_END) begin
        sub_q  <= '0;
        step_q <= step_q + 1'b1;
      end else begin
        sub_q <= sub_q + 1'b1;
      end
    end
  end

  assign step = step_q;

  // R4
  resync_clear_chk: assert property (@(posedge clk) disable iff (rst)
    resync |=> (step_q == '0 && sub_q == '0));
  // R6
  last_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (step_q == LAST_STEP && !resync) |=> step_q == LAST_STEP);
  // R9
  idle_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (!resync && !bit_stb) |=> ($stable(step_q) && $stable(sub_q)));
  // R5
  step_inc_chk: assert property (@(posedge clk) disable iff (rst)
    !resync |=> (step_q == $past(step_q) || step_q == $past(step_q) + 1'b1));
endmodule

// File: rtl/pllsched_decode.sv
module pllsched_decode #(
  parameter int unsigned STEP_W       = pllsched_pkg::DEF_BL_W,
  parameter int unsigned CARRIER_STEP = 1
) (
  input  logic [STEP_W-1:0] step,
  output logic              hw_carrier,
  output logic [STEP_W-1:0] hw_bit
);
  localparam logic [STEP_W-1:0] CAR_TH = STEP_W'(CARRIER_STEP);

  generate
    if (CARRIER_STEP == 0) begin : g_car_always_slow
      assign hw_carrier = 1'b1;
    end else begin : g_car_thresh
      assign hw_carrier = (step >= CAR_TH);
    end
  endgenerate

  assign hw_bit = step;
endmodule

// File: rtl/pllsched_outsel.sv
module pllsched_outsel #(
  parameter int unsigned BL_W = pllsched_pkg::DEF_BL_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            src_sw,
  input  logic            hw_carrier,
  input  logic [BL_W-1:0] hw_bit,
  input  logic            sw_carrier,
  input  logic [BL_W-1:0] sw_bit,
  output logic            carrier_q,
  output logic [BL_W-1:0] bit_q
);
  import pllsched_pkg::*;

  tc_src_e src;
  assign src = tc_src_e'(src_sw);

  always_ff @(posedge clk) begin
    if (rst) begin
      carrier_q <= 1'b0;
      bit_q     <= '0;
    end else if (src == TC_SRC_SW) begin
      carrier_q <= sw_carrier;
      bit_q     <= sw_bit;
    end else begin
      carrier_q <= hw_carrier;
      bit_q     <= hw_bit;
    end
  end

  // R10
  sw_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (src_sw && $past(src_sw) && $stable(sw_bit) && $stable(sw_carrier))
      |=> ($stable(bit_q) && $stable(carrier_q)));
endmodule

// File: rtl/pll_tc_sched.sv
module pll_tc_sched #(
  parameter int unsigned STEP_LEN     = pllsched_pkg::DEF_STEP_LEN,
  parameter int unsigned BL_W         = pllsched_pkg::DEF_BL_W,
  parameter int unsigned CARRIER_STEP = 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            bit_stb,
  input  logic            resync,
  input  logic            src_sw,
  input  logic            sw_carrier,
  input  logic [BL_W-1:0] sw_bit,
  output logic            carrier_sel,
  output logic [BL_W-1:0] bit_sel
);
  logic [BL_W-1:0] step;
  logic            hw_carrier;
  logic [BL_W-1:0] hw_bit;

  pllsched_step_ctr #(.STEP_LEN(STEP_LEN), .STEP_W(BL_W)) i_ctr (
    .clk(clk), .rst(rst), .bit_stb(bit_stb), .resync(resync), .step(step)
  );

  pllsched_decode #(.STEP_W(BL_W), .CARRIER_STEP(CARRIER_STEP)) i_dec (
    .step(step), .hw_carrier(hw_carrier), .hw_bit(hw_bit)
  );

  pllsched_outsel #(.BL_W(BL_W)) i_out (
    .clk(clk), .rst(rst), .src_sw(src_sw),
    .hw_carrier(hw_carrier), .hw_bit(hw_bit),
    .sw_carrier(sw_carrier), .sw_bit(sw_bit),
    .carrier_q(carrier_sel), .bit_q(bit_sel)
  );

  // R5
  carrier_fast_pair_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(src_sw) && !carrier_sel) |-> bit_sel == '0);
  // R4
  resync_out_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(resync) && !$past(src_sw) && !src_sw) |=> (!carrier_sel && bit_sel == '0));
endmodule

// File: tb/test_pll_tc_sched.sv
module test_pll_tc_sched;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 12;
  localparam int V_RS [NV] = '{1, 0, 0, 0, 0, 0, 0,   1, 0,  0,  1, 0};
  localparam int V_N  [NV] = '{0,63, 1,63, 1,64,100,  0,64, 30, 63, 1};
  localparam int V_C  [NV] = '{0, 0, 1, 1, 1, 1, 1,   0, 1,  1,  0, 1};
  localparam int V_B  [NV] = '{0, 0, 1, 1, 2, 3, 3,   0, 1,  1,  0, 1};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_stb = 1'b0, resync = 1'b0, src_sw = 1'b0, sw_carrier = 1'b0;
  logic [1:0] sw_bit = 2'b00;
  logic carrier_sel;
  logic [1:0] bit_sel;
  int n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pll_tc_sched i_pll_tc_sched (
    .clk(clk), .rst(rst), .bit_stb(bit_stb), .resync(resync), .src_sw(src_sw),
    .sw_carrier(sw_carrier), .sw_bit(sw_bit),
    .carrier_sel(carrier_sel), .bit_sel(bit_sel)
  );

  task automatic check(input string req, input logic ec, input logic [1:0] eb);
    n_chk++;
    if (carrier_sel !== ec || bit_sel !== eb) begin
      n_bad++;
      $display("FAIL %s: carrier_sel=%b bit_sel=%b expected carrier_sel=%b bit_sel=%b",
               req, carrier_sel, bit_sel, ec, eb);
    end
  endtask

  task automatic strobes(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) bit_stb = 1'b1;
      @(negedge clk) bit_stb = 1'b0;
    end
  endtask

  task automatic pulse_resync();
    @(negedge clk) resync = 1'b1;
    @(negedge clk) resync = 1'b0;
  endtask

  task automatic settle();
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not complete");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset", 1'b0, 2'b00);
    rst = 1'b0;
    settle();
    check("R1 after release", 1'b0, 2'b00);

    // R2 R4 R5 R6 R7: table walk in hardware mode
    for (int v = 0; v < NV; v++) begin
      if (V_RS[v] != 0) pulse_resync();
      strobes(V_N[v]);
      settle();
      check($sformatf("R5/R6/R7 vector %0d", v), V_C[v][0], V_B[v][1:0]);
    end

    // R10: software fields, set independently
    src_sw = 1'b1; sw_carrier = 1'b1; sw_bit = 2'b10;
    settle();
    check("R10 sw 1/10", 1'b1, 2'b10);
    sw_carrier = 1'b0; sw_bit = 2'b11;
    settle();
    check("R10 sw 0/11", 1'b0, 2'b11);
    pulse_resync();
    settle();
    check("R10 resync ignored in sw", 1'b0, 2'b11);

    // R11: schedule restarted by resync while in sw; return to hw
    src_sw = 1'b0;
    settle();
    check("R11 back to hw step0", 1'b0, 2'b00);
    src_sw = 1'b1;
    strobes(64);
    src_sw = 1'b0;
    settle();
    check("R11 counted in sw", 1'b1, 2'b01);

    // R9: idle cycles do not advance
    pulse_resync();
    strobes(63);
    repeat (200) @(negedge clk);
    check("R9 idle no advance", 1'b0, 2'b00);
    strobes(1);
    settle();
    check("R9 64th strobe steps", 1'b1, 2'b01);

    // R8: resync wins over simultaneous strobe
    pulse_resync();
    strobes(63);
    @(negedge clk) begin bit_stb = 1'b1; resync = 1'b1; end
    @(negedge clk) begin bit_stb = 1'b0; resync = 1'b0; end
    strobes(1);
    settle();
    check("R8 resync beats strobe", 1'b0, 2'b00);
    strobes(63);
    settle();
    check("R8 step after 64 more", 1'b1, 2'b01);

    // R1: reset from slowest
    strobes(192);
    settle();
    check("R6 slowest", 1'b1, 2'b11);
    @(negedge clk) rst = 1'b1;
    @(negedge clk) rst = 1'b0;
    settle();
    check("R1 reset from slowest", 1'b0, 2'b00);

    // R3: one clock latency on source switch
    sw_carrier = 1'b1; sw_bit = 2'b01;
    @(negedge clk) src_sw = 1'b1;
    check("R3 before edge", 1'b0, 2'b00);
    @(negedge clk);
    check("R3 one clock later", 1'b1, 2'b01);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule